// File: doc/BRIEF.md
# Prioritized maskable interrupt controller

This block decides which interrupt a small 8-bit processor core takes next. It watches seventeen sources: seven external pins, which are synchronized and checked for an edge of a chosen polarity; nine internal one-cycle peripheral strobes; and one software break strobe from the core. Each source except the break has its own request latch and enable bit. A global disable flag gates every source but the break. The last internal slot is shared by two peripheral strobes, and a select bit picks which of them feeds it.

When an interrupt is pending and allowed, the block raises `irq_valid_o` with the slot number and the vector address. That tells the core to push its program counter and status and to load the program counter from the vector. The core commits with a one-cycle `irq_ack_i`. That pulse clears the winning request and sets the disable flag. An 8-bit register port gives access to the enable bits, the request bits (clear only), the polarity bits, the disable flag and the shared-slot select. A write that changes a polarity bit or the shared-slot select latches a request in the slot it affects.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Slots are numbered as follows: slot 0 is the break, slots 1..7 are external pins 0..6, and slots 8..16 are internal strobes 0..8. `irq_vec_o` equals VEC_BASE minus twice the slot in `irq_id_o`. VEC_BASE defaults to 16'hFFFC.
- R2: A slot from 1 to 16 is offered only when its request bit and its enable bit are both 1 and the disable flag is 0.
- R3: The register port reads combinationally and writes on the clock edge. Its map is: address 0 holds the external enables in bits 6:0; address 1 holds the internal enables 0..7; address 2 holds the internal enable 8 in bit 0, the disable flag in bit 6 and the shared-slot select in bit 7; address 3 holds the external requests; address 4 holds the internal requests 0..7; address 5 holds the internal request 8 in bit 0 and the break pending in bit 7; address 6 holds the external polarity; address 7 reads 0.
- R4: Writing 0 to a request bit at address 3, 4 or 5 clears it. Writing 1 leaves it unchanged. The break pending bit cannot be written.
- R5: A break strobe is offered as slot 0 on the next cycle, whatever the disable flag and the enables hold.
- R6: When several slots are offered, the lowest slot number wins. `irq_valid_o` is 0 when none is offered.
- R7: An `irq_ack_i` while `irq_valid_o` is 1 clears the winner's request and sets the disable flag. An ack while `irq_valid_o` is 0 changes nothing.
- R8: Each external pin passes through two synchronizer flops before edge detection. With polarity 1 a rising edge sets the request; with polarity 0 a falling edge does. The request reads as set three clock edges after the pin changes. An edge of the other direction sets nothing.
- R9: When a hardware set and a software clear hit the same request bit in the same cycle, the bit ends up set.
- R10: A write that changes a polarity bit sets that pin's request. A write that changes the shared-slot select sets the internal request 8.
- R11: The disable flag resets to 1 and is driven on `irq_dis_o`. When an ack and a register write happen in the same cycle, the ack's set wins.
- R12: Internal slot 8 is fed by `int_req_i[8]` when the select is 0 and by `alt_req_i` when it is 1. The strobe that is not selected is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | N_EXT | External interrupt pins, asynchronous |
| int_req_i | input | N_INT | Internal peripheral request strobes |
| alt_req_i | input | 1 | Alternate strobe for the shared internal slot |
| brk_i | input | 1 | Software break strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_ack_i | input | 1 | Core acknowledge pulse |
| irq_valid_o | output | 1 | Interrupt offered: stack PC and status, then load the vector |
| irq_id_o | output | SLOT_W | Winning slot number |
| irq_vec_o | output | VEC_W | Vector address for the winning slot |
| irq_dis_o | output | 1 | Global disable flag |

## Verification
The bench steers toward the cases where a plausible bug stays hidden. A write of all ones to the request register must leave a pending interrupt in place; a design that stored the data would drop it. A strobe that lands on the same edge as a clearing write must survive; resolving the clash toward the clear loses the event. A break must be offered while the disable flag is 1; gating it would hang the core's break path. A polarity or select change must raise a request, a falling edge under rising polarity must not, and a pin edge must take exactly three edges to appear; a missing synchronizer stage would shift that timing. The strobe not chosen for the shared slot must be ignored. A long random phase compares every output against a behavioural model on every cycle, covering priority, masking and ack ordering.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam logic [2:0] A_EN_EXT   = 3'd0;
  localparam logic [2:0] A_EN_INT   = 3'd1;
  localparam logic [2:0] A_CTRL     = 3'd2;
  localparam logic [2:0] A_REQ_EXT  = 3'd3;
  localparam logic [2:0] A_REQ_INT  = 3'd4;
  localparam logic [2:0] A_REQ_MISC = 3'd5;
  localparam logic [2:0] A_POL      = 3'd6;

  localparam int unsigned CTRL_DIS_BIT = 6;
  localparam int unsigned CTRL_SEL_BIT = 7;
  localparam int unsigned MISC_BRK_BIT = 7;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // a change whose new level equals the polarity
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign edge_o[k] = (s2_q[k] ^ s3_q[k]) & ~(s2_q[k] ^ pol_i[k]);
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] req_o
);
  logic [W-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= (req_q & ~clr_i) | set_i;
  end

  assign req_o = req_q;

  p_sw_no_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_q & ~$past(req_q)) & ~$past(set_i)) == '0);

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(set_i) & ~req_q) == '0);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N        = 17,
  parameter int unsigned SLOT_W   = 5,
  parameter int unsigned VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'hFFFC
) (
  input  logic [N-1:0]      pend_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] id_o,
  output logic [N-1:0]      grant_o,
  output logic [VEC_W-1:0]  vec_o
);
  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) id_o = SLOT_W'(i);
    end
    valid_o = |pend_i;
    grant_o = '0;
    if (valid_o) grant_o[id_o] = 1'b1;
  end

  assign vec_o = VEC_BASE - VEC_W'({id_o, 1'b0});
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_EXT = 7,
  parameter int unsigned N_INT = 9,
  parameter int unsigned VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'hFFFC,
  localparam int unsigned N_SRC  = 1 + N_EXT + N_INT,
  localparam int unsigned SLOT_W = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic              alt_req_i,
  input  logic              brk_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              irq_ack_i,
  output logic              irq_valid_o,
  output logic [SLOT_W-1:0] irq_id_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              irq_dis_o
);
  localparam int unsigned EXT_LO = 1;
  localparam int unsigned INT_LO = 1 + N_EXT;
  localparam int unsigned INT_HI = N_INT - 8;

  logic [N_EXT-1:0] en_ext_q, pol_q, edge_w, pol_chg;
  logic [N_INT-1:0] en_int_q, int_src;
  logic             dis_q, sel_q, sel_chg, ack_fire;
  logic [N_SRC-1:0] req_q, set_w, clr_w, pend_w, grant_w;

  logic wr_ctrl, wr_pol;
  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_pol  = reg_we_i && (reg_addr_i == A_POL);

  irq_edge_sync #(.W(N_EXT)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .pol_i  (pol_q),
    .edge_o (edge_w)
  );

  // shared last internal slot
  always_comb begin
    int_src = int_req_i;
    int_src[N_INT-1] = sel_q ? alt_req_i : int_req_i[N_INT-1];
  end

  assign pol_chg = wr_pol ? (reg_wdata_i[N_EXT-1:0] ^ pol_q) : '0;
  assign sel_chg = wr_ctrl && (reg_wdata_i[CTRL_SEL_BIT] != sel_q);

  always_comb begin
    set_w = {int_src, edge_w | pol_chg, brk_i};
    set_w[N_SRC-1] = set_w[N_SRC-1] | sel_chg;
  end

  always_comb begin
    clr_w = '0;
    if (reg_we_i) begin
      case (reg_addr_i)
        A_REQ_EXT:  clr_w[EXT_LO +: N_EXT]    = ~reg_wdata_i[N_EXT-1:0];
        A_REQ_INT:  clr_w[INT_LO +: 8]        = ~reg_wdata_i;
        A_REQ_MISC: clr_w[INT_LO + 8 +: INT_HI] = ~reg_wdata_i[INT_HI-1:0];
        default: ;
      endcase
    end
    if (ack_fire) clr_w = clr_w | grant_w;
  end

  irq_req_bank #(.W(N_SRC)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_w),
    .clr_i  (clr_w),
    .req_o  (req_q)
  );

  assign pend_w = {req_q[N_SRC-1:1] & {en_int_q, en_ext_q} & {(N_SRC-1){~dis_q}}, req_q[0]};

  irq_prio_enc #(
    .N        (N_SRC),
    .SLOT_W   (SLOT_W),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
  ) u_enc (
    .pend_i  (pend_w),
    .valid_o (irq_valid_o),
    .id_o    (irq_id_o),
    .grant_o (grant_w),
    .vec_o   (irq_vec_o)
  );

  assign ack_fire = irq_ack_i && irq_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_ext_q <= '0;
      en_int_q <= '0;
      pol_q    <= '0;
      dis_q    <= 1'b1;
      sel_q    <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          A_EN_EXT: en_ext_q <= reg_wdata_i[N_EXT-1:0];
          A_EN_INT: en_int_q[7:0] <= reg_wdata_i;
          A_CTRL: begin
            en_int_q[N_INT-1:8] <= reg_wdata_i[INT_HI-1:0];
            dis_q <= reg_wdata_i[CTRL_DIS_BIT];
            sel_q <= reg_wdata_i[CTRL_SEL_BIT];
          end
          A_POL: pol_q <= reg_wdata_i[N_EXT-1:0];
          default: ;
        endcase
      end
      if (ack_fire) dis_q <= 1'b1;
    end
  end

  assign irq_dis_o = dis_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_EN_EXT:  reg_rdata_o = 8'(en_ext_q);
      A_EN_INT:  reg_rdata_o = en_int_q[7:0];
      A_CTRL: begin
        reg_rdata_o[INT_HI-1:0]   = en_int_q[N_INT-1:8];
        reg_rdata_o[CTRL_DIS_BIT] = dis_q;
        reg_rdata_o[CTRL_SEL_BIT] = sel_q;
      end
      A_REQ_EXT: reg_rdata_o = 8'(req_q[EXT_LO +: N_EXT]);
      A_REQ_INT: reg_rdata_o = req_q[INT_LO +: 8];
      A_REQ_MISC: begin
        reg_rdata_o[INT_HI-1:0]   = req_q[INT_LO + 8 +: INT_HI];
        reg_rdata_o[MISC_BRK_BIT] = req_q[0];
      end
      A_POL:     reg_rdata_o = 8'(pol_q);
      default: ;
    endcase
  end

  p_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && irq_id_o != '0) |-> !dis_q);

  p_brk_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q[0] |-> (irq_valid_o && irq_id_o == '0));

  p_ack_sets_dis_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_valid_o) |=> irq_dis_o);

  p_pol_spur_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pol_chg) |=> ((req_q[EXT_LO +: N_EXT] & $past(pol_chg)) == $past(pol_chg)));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [6:0] ext_pin = '0;
  logic [8:0] int_req = '0;
  logic       alt_req = 1'b0, brk = 1'b0, we = 1'b0, ack = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       valid, dis;
  logic [4:0] id;
  logic [15:0] vec;

  int total = 0, bad = 0;
  bit done = 0;

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(ext_pin), .int_req_i(int_req),
    .alt_req_i(alt_req), .brk_i(brk), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_ack_i(ack),
    .irq_valid_o(valid), .irq_id_o(id), .irq_vec_o(vec), .irq_dis_o(dis)
  );

  // behavioural reference
  bit m_req[17], m_en[17], m_pol[7], m_p1[7], m_p2[7], m_p3[7];
  bit m_dis, m_sel;

  function automatic int m_winner();
    for (int i = 0; i < 17; i++) begin
      if (i == 0 && m_req[0]) return 0;
      if (i > 0 && m_req[i] && m_en[i] && !m_dis) return i;
    end
    return -1;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    logic [7:0] r = '0;
    case (a)
      3'd0: for (int k = 0; k < 7; k++) r[k] = m_en[1+k];
      3'd1: for (int k = 0; k < 8; k++) r[k] = m_en[8+k];
      3'd2: begin r[0] = m_en[16]; r[6] = m_dis; r[7] = m_sel; end
      3'd3: for (int k = 0; k < 7; k++) r[k] = m_req[1+k];
      3'd4: for (int k = 0; k < 8; k++) r[k] = m_req[8+k];
      3'd5: begin r[0] = m_req[16]; r[7] = m_req[0]; end
      3'd6: for (int k = 0; k < 7; k++) r[k] = m_pol[k];
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 17; i++) begin m_req[i] = 0; m_en[i] = 0; end
      for (int k = 0; k < 7; k++) begin m_pol[k] = 0; m_p1[k] = 0; m_p2[k] = 0; m_p3[k] = 0; end
      m_dis = 1; m_sel = 0;
    end else begin
      int w;
      bit st[17], cl[17];
      w = m_winner();
      for (int i = 0; i < 17; i++) begin st[i] = 0; cl[i] = 0; end
      st[0] = brk;
      for (int k = 0; k < 7; k++)
        if (m_p2[k] != m_p3[k] && m_p2[k] == m_pol[k]) st[1+k] = 1;
      for (int k = 0; k < 9; k++) begin
        bit s;
        s = (k == 8) ? (m_sel ? alt_req : int_req[8]) : int_req[k];
        if (s) st[8+k] = 1;
      end
      if (we) begin
        case (addr)
          3'd6: for (int k = 0; k < 7; k++) if (wdata[k] != m_pol[k]) st[1+k] = 1;
          3'd2: if (wdata[7] != m_sel) st[16] = 1;
          3'd3: for (int k = 0; k < 7; k++) if (!wdata[k]) cl[1+k] = 1;
          3'd4: for (int k = 0; k < 8; k++) if (!wdata[k]) cl[8+k] = 1;
          3'd5: if (!wdata[0]) cl[16] = 1;
          default: ;
        endcase
      end
      if (ack && w >= 0) cl[w] = 1;
      for (int i = 0; i < 17; i++) m_req[i] = st[i] | (m_req[i] & !cl[i]);
      if (we) begin
        case (addr)
          3'd0: for (int k = 0; k < 7; k++) m_en[1+k] = wdata[k];
          3'd1: for (int k = 0; k < 8; k++) m_en[8+k] = wdata[k];
          3'd2: begin m_en[16] = wdata[0]; m_dis = wdata[6]; m_sel = wdata[7]; end
          3'd6: for (int k = 0; k < 7; k++) m_pol[k] = wdata[k];
          default: ;
        endcase
      end
      if (ack && w >= 0) m_dis = 1;
      for (int k = 0; k < 7; k++) begin m_p3[k] = m_p2[k]; m_p2[k] = m_p1[k]; m_p1[k] = ext_pin[k]; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int w;
    w = m_winner();
    chk("R6 valid", 32'(valid), 32'(w >= 0));
    if (w >= 0) begin
      chk("R6 id", 32'(id), 32'(w));
      chk("R1 vec", 32'(vec), 32'(16'hFFFC - 16'(2 * w)));
    end
    chk("R11 dis", 32'(dis), 32'(m_dis));
    chk("R3 rdata", 32'(rdata), 32'(m_read(addr)));
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
    compare_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    tick();
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R6 reset valid", 32'(valid), 0);
    chk("R11 reset dis", 32'(dis), 1);

    // masked by disable flag
    wr(3'd1, 8'h01);
    int_req[0] = 1; tick(); int_req[0] = 0;
    chk("R2 masked by dis", 32'(valid), 0);
    wr(3'd2, 8'h00);
    chk("R11 dis written 0", 32'(dis), 0);
    chk("R2 offered", 32'(valid), 1);
    chk("R1 vec slot8", 32'(vec), 32'h0000FFEC);

    // write 1 keeps, write 0 clears
    wr(3'd4, 8'hFF);
    chk("R4 write one no effect", 32'(valid), 1);
    wr(3'd4, 8'h00);
    chk("R4 write zero clears", 32'(valid), 0);

    // polarity change latches request; priority
    wr(3'd0, 8'h08);
    int_req[0] = 1; tick(); int_req[0] = 0;
    wr(3'd6, 8'h08);
    rd(3'd3, d);
    chk("R10 pol change sets req", 32'(d), 32'h08);
    chk("R6 ext3 beats int0", 32'(id), 4);
    chk("R1 vec slot4", 32'(vec), 32'h0000FFF4);

    ack = 1; tick(); ack = 0;
    chk("R7 ack sets dis", 32'(dis), 1);
    rd(3'd3, d);
    chk("R7 ack clears winner", 32'(d), 0);
    chk("R2 int0 masked after ack", 32'(valid), 0);

    // break unmaskable
    brk = 1; tick(); brk = 0;
    chk("R5 brk offered", 32'(valid), 1);
    chk("R5 brk id", 32'(id), 0);
    chk("R1 brk vec", 32'(vec), 32'h0000FFFC);
    ack = 1; tick(); ack = 0;
    chk("R5 brk cleared", 32'(valid), 0);

    // pin edge timing
    addr = 3'd3;
    ext_pin[3] = 1;
    tick(); tick();
    chk("R8 not yet", 32'(rdata), 0);
    tick();
    chk("R8 rising edge latched", 32'(rdata), 32'h08);
    wr(3'd3, 8'h00);
    addr = 3'd3;
    ext_pin[3] = 0;
    repeat (4) tick();
    chk("R8 falling ignored", 32'(rdata), 0);

    // set beats clear
    int_req[1] = 1; we = 1; addr = 3'd4; wdata = 8'h00;
    tick();
    int_req[1] = 0; we = 0;
    rd(3'd4, d);
    chk("R9 set wins", 32'(d), 32'h02);

    // shared slot
    wr(3'd2, 8'hC0);
    rd(3'd5, d);
    chk("R10 select change sets req", 32'(d), 32'h01);
    wr(3'd5, 8'h00);
    int_req[8] = 1; tick(); int_req[8] = 0;
    rd(3'd5, d);
    chk("R12 unselected ignored", 32'(d), 0);
    alt_req = 1; tick(); alt_req = 0;
    rd(3'd5, d);
    chk("R12 alt selected", 32'(d), 32'h01);

    // ack without valid
    ack = 1; tick(); ack = 0;
    chk("R7 idle ack dis", 32'(dis), 1);
    rd(3'd4, d);
    chk("R7 idle ack keeps req", 32'(d), 32'h02);
    rd(3'd1, d);
    chk("R3 enable readback", 32'(d), 32'h01);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      ext_pin = ($urandom_range(0, 7) == 0) ? 7'($urandom) : ext_pin;
      int_req = ($urandom_range(0, 3) == 0) ? 9'($urandom) & 9'($urandom) : '0;
      alt_req = ($urandom_range(0, 5) == 0);
      brk = ($urandom_range(0, 30) == 0);
      ack = ($urandom_range(0, 3) == 0);
      we = ($urandom_range(0, 4) == 0);
      addr = 3'($urandom);
      wdata = 8'($urandom);
      if (we && addr == 3'd2 && $urandom_range(0, 1) == 1) wdata[6] = 0;
      tick();
    end
    int_req = '0; alt_req = 0; brk = 0; ack = 0; we = 0;
    tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule